// File: doc/BRIEF.md
# SPI Serial Clock and Frame Delay Sequencer

This block drives the timing side of an SPI controller from a single system clock. It holds the serial clock at its idle level while nothing is happening. When a frame is requested it activates chip select and waits a programmable lead-in time. It then toggles the serial clock at a programmable rate until the shift logic reports that the current bit is the last one. After that it waits a programmable tail time before chip select is released, and a further programmable gap before the next frame may begin. Each clock edge comes with a one-cycle strobe that tells the shift logic whether to capture or to launch data.

All timing comes from a 32-bit attribute word, and software works out the field values. The serial clock period is the product of a prime prescaler and a scaler drawn from a nonlinear table. Each of the three delays is the product of an odd prescaler and a power of two. The attribute word is captured when a frame starts, so the word may change freely while a frame is running.

Top module: `spi_timing_gen`

## Requirements
- R1: While reset is high, and in the cycle after, sck_o, cs_act_o, busy_o and all five strobes are low.
- R2: Outside a frame, sck_o sits at the polarity bit (attribute bit 26). In the idle state it follows the live attribute input one cycle late. From chip-select release until the gap ends it holds the captured value.
- R3: A start_i pulse seen while the block is idle makes cs_act_o and busy_o high in the next cycle and captures the attribute word. Later changes to attr_i have no effect on that frame. lsb_first_o shows bit 24, and frame_bits_o shows bits 30:27 plus one.
- R4: The first serial clock edge, together with asrt_done_o, comes La cycles after chip select goes active. La = (2p+1) * 2^(s+1), where p is bits 23:22 and s is bits 15:12.
- R5: The serial clock period is B * S system clocks. B is 2, 3, 5 or 7 for codes 0 to 3 in bits 17:16. S comes from bits 3:0: codes 0 to 3 give 2, 4, 6 and 8, and a code n of 4 or more gives 2^n.
- R6: Each period begins with the edge that leaves the idle level. The high phase lasts ceil(period/2) cycles and the low phase lasts floor(period/2).
- R7: Every serial clock edge has exactly one one-cycle strobe, and the strobe appears in the cycle where sck_o changes. With the phase bit (bit 25) at 0, leading edges give cap_stb_o and trailing edges give shf_stb_o. With the phase bit at 1 the two are swapped.
- R8: A frame_done_i pulse sampled at any rising clock edge after the previous trailing edge makes that bit's trailing edge the last edge of the frame.
- R9: Chip select goes inactive, together with aftr_done_o, Lb cycles after the last trailing edge. Lb uses the same formula as La with bits 21:20 and 11:8.
- R10: gap_done_o pulses Lc cycles after chip select goes inactive, and busy_o is low from that cycle on. Lc uses the same formula with bits 19:18 and 7:4.
- R11: A start_i pulse while busy_o is high is ignored, and nothing is left pending after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_i | input | 32 | Attribute word (timing fields, polarity, phase, bit order, frame size) |
| start_i | input | 1 | Request a frame; honoured only while idle |
| frame_done_i | input | 1 | From the shift logic: the current bit is the last one |
| sck_o | output | 1 | Serial clock |
| cap_stb_o | output | 1 | One-cycle strobe on each capture edge |
| shf_stb_o | output | 1 | One-cycle strobe on each launch edge |
| cs_act_o | output | 1 | Chip select active (high = selected) |
| asrt_done_o | output | 1 | Lead-in delay ended; first edge in this cycle |
| aftr_done_o | output | 1 | Tail delay ended; chip select released |
| gap_done_o | output | 1 | Inter-frame gap ended |
| busy_o | output | 1 | A frame or one of its delays is in progress |
| lsb_first_o | output | 1 | Captured bit-order flag |
| frame_bits_o | output | 5 | Captured frame length in bits |

## Verification
A wrong counter load shows at once as a misplaced serial clock edge or chip-select transition. The distance between two events at the ports then differs from the closed-form value, and the bench measures every lead-in, half period, tail and gap this way. A wrong phase flag in the state machine shows within one edge as a swapped capture and shift strobe. A stale frame-end latch adds or drops a whole clock period, which the edge count at chip-select release exposes. A start that is wrongly accepted or left pending appears as busy_o rising after the gap, which the bench watches for several cycles.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

  // Attribute word; field positions are decoded by software
  typedef struct packed {
    logic       rsv;
    logic [3:0] fsz;      // frame length minus one
    logic       pol;      // serial clock idle level
    logic       pha;      // 1: capture on trailing edge
    logic       lsb;      // bit order flag
    logic [1:0] pp_lead;  // lead-in prescaler code
    logic [1:0] pp_lag;   // tail prescaler code
    logic [1:0] pp_gap;   // gap prescaler code
    logic [1:0] pp_baud;  // baud prescaler code
    logic [3:0] sc_lead;
    logic [3:0] sc_lag;
    logic [3:0] sc_gap;
    logic [3:0] sc_baud;
  } tm_attr_t;

  typedef enum logic [2:0] {
    TM_IDLE, TM_LEAD, TM_RUN, TM_LAG, TM_GAP
  } tm_state_e;

  function automatic int unsigned baud_pre(input logic [1:0] code);
    case (code)
      2'd0:    return 32'd2;
      2'd1:    return 32'd3;
      2'd2:    return 32'd5;
      default: return 32'd7;
    endcase
  endfunction

  function automatic int unsigned baud_scl(input logic [3:0] code);
    if (code < 4'd4) return (32'(code) + 32'd1) * 32'd2;
    return 32'd1 << code;
  endfunction

  function automatic int unsigned dly_cycles(input logic [1:0] p, input logic [3:0] s);
    return (32'(p) * 32'd2 + 32'd1) << (32'(s) + 32'd1);
  endfunction

endpackage

// File: rtl/spi_tm_cnt.sv
module spi_tm_cnt #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/spi_tm_sck.sv
module spi_tm_sck #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle_lvl,
  input  logic          pha,
  input  logic [CW-1:0] h1,
  input  logic [CW-1:0] h2,
  input  logic          launch,
  input  logic          stop,
  output logic          sck_o,
  output logic          cap_o,
  output logic          shf_o,
  output logic          trail_now
);
  logic          run, first, zero, ld;
  logic [CW-1:0] ldv;

  assign trail_now = run & first & zero;
  assign ld        = launch | (run & zero & ~(first & stop));
  assign ldv       = (launch | ~first) ? h1 - 1'b1 : h2 - 1'b1;

  spi_tm_cnt #(.CW(CW)) u_half (
    .clk(clk), .rst(rst), .load(ld), .val(ldv), .zero(zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_o <= 1'b0;
      run   <= 1'b0;
      first <= 1'b0;
      cap_o <= 1'b0;
      shf_o <= 1'b0;
    end else begin
      cap_o <= 1'b0;
      shf_o <= 1'b0;
      if (launch) begin
        sck_o <= ~idle_lvl;
        run   <= 1'b1;
        first <= 1'b1;
        cap_o <= ~pha;
        shf_o <= pha;
      end else if (run && zero) begin
        if (first) begin
          sck_o <= idle_lvl;
          first <= 1'b0;
          cap_o <= pha;
          shf_o <= ~pha;
          if (stop) run <= 1'b0;
        end else begin
          sck_o <= ~idle_lvl;
          first <= 1'b1;
          cap_o <= ~pha;
          shf_o <= pha;
        end
      end else if (!run) begin
        sck_o <= idle_lvl;
      end
    end
  end
endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
  import spi_tm_pkg::*;
#(
  parameter int CW  = 20,
  parameter int FBW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [31:0]    attr_i,
  input  logic           start_i,
  input  logic           frame_done_i,
  output logic           sck_o,
  output logic           cap_stb_o,
  output logic           shf_stb_o,
  output logic           cs_act_o,
  output logic           asrt_done_o,
  output logic           aftr_done_o,
  output logic           gap_done_o,
  output logic           busy_o,
  output logic           lsb_first_o,
  output logic [FBW-1:0] frame_bits_o
);
  localparam int FSZ_W = $bits(attr_i[30:27]);

  tm_attr_t      live, cfg;
  tm_state_e     st;
  logic          dly_zero, dly_ld, launch, trail_now, fin, stop, end_now;
  logic [CW-1:0] dly_val, per, h_hi, h_lo, h1, h2;
  logic          unused_fields;

  assign live = tm_attr_t'(attr_i);
  assign unused_fields = ^{cfg.rsv, cfg.pp_lead, cfg.sc_lead};

  // Half-period lengths; an odd product gives the spare cycle to the high phase
  assign per  = CW'(baud_pre(cfg.pp_baud) * baud_scl(cfg.sc_baud));
  assign h_lo = per >> 1;
  assign h_hi = (per >> 1) + CW'(per[0]);
  assign h1   = cfg.pol ? h_lo : h_hi;
  assign h2   = cfg.pol ? h_hi : h_lo;

  assign launch  = (st == TM_LEAD) && dly_zero;
  assign stop    = fin | frame_done_i;
  assign end_now = (st == TM_RUN) && trail_now && stop;

  always_comb begin
    dly_ld  = 1'b0;
    dly_val = '0;
    case (st)
      TM_IDLE: if (start_i) begin
        dly_ld  = 1'b1;
        dly_val = CW'(dly_cycles(live.pp_lead, live.sc_lead) - 32'd1);
      end
      TM_RUN: if (end_now) begin
        dly_ld  = 1'b1;
        dly_val = CW'(dly_cycles(cfg.pp_lag, cfg.sc_lag) - 32'd1);
      end
      TM_LAG: if (dly_zero) begin
        dly_ld  = 1'b1;
        dly_val = CW'(dly_cycles(cfg.pp_gap, cfg.sc_gap) - 32'd1);
      end
      default: ;
    endcase
  end

  spi_tm_cnt #(.CW(CW)) u_dly (
    .clk(clk), .rst(rst), .load(dly_ld), .val(dly_val), .zero(dly_zero)
  );

  spi_tm_sck #(.CW(CW)) u_sck (
    .clk(clk), .rst(rst),
    .idle_lvl(st == TM_IDLE ? live.pol : cfg.pol),
    .pha(cfg.pha), .h1(h1), .h2(h2),
    .launch(launch), .stop(stop),
    .sck_o(sck_o), .cap_o(cap_stb_o), .shf_o(shf_stb_o),
    .trail_now(trail_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= TM_IDLE;
      cfg         <= '0;
      cs_act_o    <= 1'b0;
      asrt_done_o <= 1'b0;
      aftr_done_o <= 1'b0;
      gap_done_o  <= 1'b0;
      fin         <= 1'b0;
    end else begin
      asrt_done_o <= 1'b0;
      aftr_done_o <= 1'b0;
      gap_done_o  <= 1'b0;
      case (st)
        TM_IDLE: if (start_i) begin
          cfg      <= live;
          cs_act_o <= 1'b1;
          st       <= TM_LEAD;
        end
        TM_LEAD: if (dly_zero) begin
          st          <= TM_RUN;
          asrt_done_o <= 1'b1;
          fin         <= 1'b0;
        end
        TM_RUN: begin
          if (end_now) begin
            st  <= TM_LAG;
            fin <= 1'b0;
          end else if (trail_now) begin
            fin <= 1'b0;
          end else if (frame_done_i) begin
            fin <= 1'b1;
          end
        end
        TM_LAG: if (dly_zero) begin
          cs_act_o    <= 1'b0;
          aftr_done_o <= 1'b1;
          st          <= TM_GAP;
        end
        TM_GAP: if (dly_zero) begin
          st         <= TM_IDLE;
          gap_done_o <= 1'b1;
        end
        default: st <= TM_IDLE;
      endcase
    end
  end

  assign busy_o       = (st != TM_IDLE);
  assign lsb_first_o  = cfg.lsb;
  assign frame_bits_o = FBW'({1'b0, cfg.fsz}) + FBW'(1);

  initial begin
    if (FBW <= FSZ_W) $error("frame_bits_o too narrow");
  end
endmodule

// File: rtl/spi_timing_gen_chk.sv
module spi_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic idle_pol,
  input logic start_i,
  input logic sck_o,
  input logic cap_stb_o,
  input logic shf_stb_o,
  input logic cs_act_o,
  input logic asrt_done_o,
  input logic aftr_done_o,
  input logic gap_done_o,
  input logic busy_o
);
  // R7
  edge_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cs_act_o && $past(cs_act_o)) |->
      ((cap_stb_o || shf_stb_o) == (sck_o != $past(sck_o))));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_stb_o, shf_stb_o}));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !busy_o && !$past(busy_o)) |-> (sck_o == $past(idle_pol)));

  // R2
  gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !cs_act_o) |-> $stable(sck_o));

  // R3
  start_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (cs_act_o && busy_o));

  // R11
  cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_act_o) |-> ($past(start_i) && !$past(busy_o)));

  // R4
  asrt_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && asrt_done_o) |-> (cs_act_o && (sck_o != $past(sck_o))));

  // R9
  aftr_cs_chk: assert property (@(posedge clk) disable iff (rst)
    aftr_done_o |-> ($fell(cs_act_o) && $stable(sck_o)));

  // R10
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    gap_done_o |-> (!busy_o && !cs_act_o && $past(busy_o)));
endmodule

bind spi_timing_gen spi_timing_gen_chk u_chk (
  .clk(clk), .rst(rst), .idle_pol(attr_i[26]), .start_i(start_i),
  .sck_o(sck_o), .cap_stb_o(cap_stb_o), .shf_stb_o(shf_stb_o),
  .cs_act_o(cs_act_o), .asrt_done_o(asrt_done_o), .aftr_done_o(aftr_done_o),
  .gap_done_o(gap_done_o), .busy_o(busy_o)
);

// File: tb/test_spi_timing_gen.sv
module test_spi_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] attr = '0;
  logic        start = 1'b0, fdone = 1'b0;
  logic        sck, cap, shf, cs, asrt, aftr, gapd, busy, lsbf;
  logic [4:0]  fbits;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_timing_gen i_spi_timing_gen (
    .clk(clk), .rst(rst), .attr_i(attr), .start_i(start), .frame_done_i(fdone),
    .sck_o(sck), .cap_stb_o(cap), .shf_stb_o(shf), .cs_act_o(cs),
    .asrt_done_o(asrt), .aftr_done_o(aftr), .gap_done_o(gapd), .busy_o(busy),
    .lsb_first_o(lsbf), .frame_bits_o(fbits)
  );

  function automatic logic [31:0] mk(input int fs, input bit pol, input bit pha, input bit lsb,
                                     input int pl, input int pa, input int pg, input int pb,
                                     input int sl, input int sa, input int sg, input int sb);
    return {1'b0, 4'(fs), pol, pha, lsb, 2'(pl), 2'(pa), 2'(pg), 2'(pb),
            4'(sl), 4'(sa), 4'(sg), 4'(sb)};
  endfunction

  // {bits in frame, attribute word}
  localparam logic [39:0] VEC [6] = '{
    {8'd3, mk(7, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0)},
    {8'd2, mk(15, 1, 1, 1, 2, 3, 0, 1, 1, 0, 0, 1)},
    {8'd1, mk(0, 0, 1, 0, 0, 1, 2, 3, 0, 0, 1, 2)},
    {8'd2, mk(4, 1, 0, 1, 3, 3, 3, 2, 3, 3, 2, 4)},
    {8'd4, mk(9, 0, 0, 0, 1, 2, 3, 0, 6, 2, 1, 3)},
    {8'd5, mk(11, 1, 1, 0, 0, 0, 0, 1, 2, 5, 0, 0)}
  };

  function automatic longint e_dly(input logic [1:0] p, input logic [3:0] s);
    longint m = 1;
    for (int k = 0; k <= int'(s); k++) m = m * 2;
    return (2 * longint'(p) + 1) * m;
  endfunction

  function automatic longint e_baud(input logic [1:0] p, input logic [3:0] s);
    longint pre, scl;
    case (p) 2'd0: pre = 2; 2'd1: pre = 3; 2'd2: pre = 5; default: pre = 7; endcase
    if (s <= 4'd3) scl = 2 * (longint'(s) + 1);
    else begin
      scl = 1;
      for (int k = 0; k < int'(s); k++) scl = scl * 2;
    end
    return pre * scl;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] a, input int nb, input bit alt, input bit poke);
    bit     pol = a[26], pha = a[25];
    longint la = e_dly(a[23:22], a[15:12]);
    longint lb = e_dly(a[21:20], a[11:8]);
    longint lc = e_dly(a[19:18], a[7:4]);
    longint per = e_baud(a[17:16], a[3:0]);
    longint h1 = pol ? per / 2 : (per + 1) / 2;
    longint h2 = pol ? (per + 1) / 2 : per / 2;
    longint t = 0, t_lead = 0, t_trail = 0, t_fall = -1, t_l1 = 0;
    int     leads = 0;
    bit     prev = pol, done = 0, s_ok = 1, k_ok = 1;
    @(negedge clk); attr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (alt) attr = ~a;
    chk("R3 cs active", cs, 1);
    chk("R3 busy", busy, 1);
    chk("R3 bit order", lsbf, a[24]);
    chk("R3 frame bits", fbits, a[30:27] + 1);
    chk("R2 sck idle at start", sck, pol);
    while (!done && t < 190000) begin
      fdone = 1'b0;
      start = (poke && t == 3);
      if (sck != prev) begin
        if (sck != pol) begin
          if (leads == 0) begin
            chk("R4 lead-in", t, la);
            chk("R4 strobe", asrt, 1);
            t_l1 = t;
          end else begin
            chk("R6 low/idle phase", t - t_trail, h2);
            if (leads == 1) chk("R5 period", t - t_l1, per);
          end
          if (cap != !pha || shf != pha) s_ok = 0;
          leads++; t_lead = t;
          if (leads == nb) fdone = 1'b1;
        end else begin
          chk("R6 active phase", t - t_lead, h1);
          if (cap != pha || shf != !pha) s_ok = 0;
          t_trail = t;
        end
      end else if (cap || shf) s_ok = 0;
      if (t_fall < 0 && !cs) begin
        t_fall = t;
        chk("R9 tail", t - t_trail, lb);
        chk("R9 strobe", aftr, 1);
        chk("R8 edge count", leads, nb);
      end
      if (t_fall >= 0 && sck != pol) k_ok = 0;
      if (gapd) begin
        chk("R10 gap", t - t_fall, lc);
        chk("R10 busy low", busy, 0);
        done = 1;
      end
      prev = sck;
      if (!done) begin @(negedge clk); t++; end
    end
    fdone = 1'b0; start = 1'b0;
    chk("R10 frame completed", done, 1);
    chk("R7 strobe pairing", s_ok, 1);
    chk("R2 sck idle after release", k_ok, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sck", sck, 0); chk("R1 cs", cs, 0); chk("R1 busy", busy, 0);
    chk("R1 strobes", {cap, shf, asrt, aftr, gapd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {sck, cs, busy, cap, shf, asrt, aftr, gapd}, 0);

    // R2: idle level follows polarity bit
    attr = 32'h0400_0000;
    @(negedge clk); @(negedge clk);
    chk("R2 idle high", sck, 1);
    attr = 32'h0;
    @(negedge clk); @(negedge clk);
    chk("R2 idle low", sck, 0);

    // Table walk
    for (int i = 0; i < 6; i++) run_frame(VEC[i][31:0], int'(VEC[i][39:32]), 1'b0, 1'b0);

    // R3: attribute changed right after start has no effect
    run_frame(VEC[1][31:0], int'(VEC[1][39:32]), 1'b1, 1'b0);

    // R11: start while busy is ignored and not left pending
    run_frame(VEC[0][31:0], int'(VEC[0][39:32]), 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R11 stays idle", {busy, cs}, 0);
    end

    // R4/R5 corner: largest delay scaler code, large baud scaler
    run_frame(mk(7, 0, 0, 0, 0, 0, 0, 0, 15, 0, 0, 9), 1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule